// File: doc/BRIEF.md
# Store-Load Address Overlap Detector

This block keeps a record of the latest store issued in the current dispatch group and tells the group hazard checker whether a load presented now may touch the bytes that store wrote. The comparison does not use computed effective addresses. Each address is given as two operands. Each operand is either a register tag or a signed constant offset, and a flag tells which. Each access also carries a byte count.

A store is recorded on a capture pulse, and a newer capture replaces the older record. A load reports overlap in three cases. The first is when its operand pair is the same as the recorded pair. The second is when its pair is the recorded pair with the two operands swapped. The third is when the second operands agree, both first operands are constants, and the two byte ranges intersect. A clear pulse at group end empties the record, and a clear takes priority over a capture in the same cycle. The overlap output is combinational from the load inputs and the registered record.

Top module: `st_ld_overlap`

## Requirements
- R1: With a record present and `ld_valid` high, `overlap` is 1 in the same cycle when the load's first operand equals the store's first operand and the load's second equals the store's second. Two operands are equal only if both their constant flags and their values are equal, so register tag 8 is not equal to constant 8.
- R2: `overlap` is also 1 when the load's first operand equals the store's second operand and the load's second equals the store's first.
- R3: When the second operands are equal, both first operands are constants, and the store offset is less than the load offset, `overlap` is 1 exactly when store offset + store size > load offset (R1 and R2 apart).
- R4: In the same situation with the store offset greater than or equal to the load offset, `overlap` is 1 exactly when load offset + load size > store offset.
- R5: Sizes are byte counts taken from `st_size` and `ld_size`: 4 for a word access and 8 for a double-precision access.
- R6: A record whose size is zero is empty. The record is empty after reset and after `grp_clear`, and an empty record never produces `overlap`.
- R7: `st_capture` loads the store's operands and size into the record at the clock edge, and this replaces any earlier store. Loads are compared only with the most recent store. Without a capture or a clear, the record holds.
- R8: When `grp_clear` and `st_capture` are both high in one cycle, the record ends up empty.
- R9: Offsets are signed 16-bit two's complement. The range sums are taken in signed 18-bit arithmetic, so they do not wrap. For example, a store at 32764 of size 8 overlaps a load at 32766.
- R10: While `ld_valid` is low, `overlap` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the record |
| grp_clear | input | 1 | Group end: empties the record (has priority over capture) |
| st_capture | input | 1 | Record the store presented on the st_* inputs |
| st_a_const | input | 1 | Store first operand is a constant (1) or a register tag (0) |
| st_a_val | input | 16 | Store first operand value |
| st_b_const | input | 1 | Store second operand is a constant (1) or a register tag (0) |
| st_b_val | input | 16 | Store second operand value |
| st_size | input | 4 | Store size in bytes |
| ld_valid | input | 1 | A load is presented |
| ld_a_const | input | 1 | Load first operand is a constant (1) or a register tag (0) |
| ld_a_val | input | 16 | Load first operand value |
| ld_b_const | input | 1 | Load second operand is a constant (1) or a register tag (0) |
| ld_b_val | input | 16 | Load second operand value |
| ld_size | input | 4 | Load size in bytes |
| overlap | output | 1 | The load may hit the bytes of the recorded store |

## Verification
The assertions check the following on every cycle:
- the idle-load rule and the empty-record rule;
- that a clear empties the record, even when a capture arrives in the same cycle;
- that a capture replaces the record and the record otherwise holds;
- that exact and swapped operand matches always raise overlap.

The byte-range arithmetic can only be shown by the bench's scenarios. These cover both orderings of the offsets, the edges where the ranges touch but do not intersect, word and double sizes, negative offsets, and offsets near the 16-bit limits where a narrow sum would wrap. The scenarios also show that a load matching an older store is ignored.

// File: rtl/sld_pkg.sv
package sld_pkg;
    parameter int VAL_W  = 16;
    parameter int SIZE_W = 4;
    localparam int EXT_W = VAL_W + 2;

    typedef struct packed {
        logic             is_const;
        logic [VAL_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        opnd_t             a;
        opnd_t             b;
        logic [SIZE_W-1:0] size;
    } rec_t;
endpackage

// File: rtl/sld_record.sv
module sld_record
    import sld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    input  rec_t cap_in,
    output rec_t rec_q
);
    rec_t rec_d;

    always_comb begin
        rec_d = rec_q;
        if (clear) begin
            rec_d = '0;
        end else if (capture) begin
            rec_d = cap_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end
endmodule

// File: rtl/sld_pair_match.sv
module sld_pair_match
    import sld_pkg::*;
(
    input  opnd_t st_a,
    input  opnd_t st_b,
    input  opnd_t ld_a,
    input  opnd_t ld_b,
    output logic  same_order,
    output logic  swapped,
    output logic  second_eq,
    output logic  both_const
);
    always_comb begin
        second_eq  = (ld_b == st_b);
        same_order = (ld_a == st_a) && second_eq;
        swapped    = (ld_a == st_b) && (ld_b == st_a);
        both_const = st_a.is_const && ld_a.is_const;
    end
endmodule

// File: rtl/sld_range_cmp.sv
module sld_range_cmp #(
    parameter int VW = 16,
    parameter int SW = 4
) (
    input  logic [VW-1:0] st_off,
    input  logic [SW-1:0] st_size,
    input  logic [VW-1:0] ld_off,
    input  logic [SW-1:0] ld_size,
    output logic          hit
);
    localparam int XW = VW + 2;

    logic signed [XW-1:0] st_x;
    logic signed [XW-1:0] ld_x;
    logic signed [XW-1:0] st_len;
    logic signed [XW-1:0] ld_len;
    logic signed [XW-1:0] st_end;
    logic signed [XW-1:0] ld_end;

    always_comb begin
        st_x   = {{2{st_off[VW-1]}}, st_off};
        ld_x   = {{2{ld_off[VW-1]}}, ld_off};
        st_len = {{(XW-SW){1'b0}}, st_size};
        ld_len = {{(XW-SW){1'b0}}, ld_size};
        st_end = st_x + st_len;
        ld_end = ld_x + ld_len;
        if (st_x < ld_x) begin
            hit = (st_end > ld_x);
        end else begin
            hit = (ld_end > st_x);
        end
    end
endmodule

// File: rtl/st_ld_overlap.sv
module st_ld_overlap
    import sld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_clear,
    input  logic              st_capture,
    input  logic              st_a_const,
    input  logic [VAL_W-1:0]  st_a_val,
    input  logic              st_b_const,
    input  logic [VAL_W-1:0]  st_b_val,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ld_valid,
    input  logic              ld_a_const,
    input  logic [VAL_W-1:0]  ld_a_val,
    input  logic              ld_b_const,
    input  logic [VAL_W-1:0]  ld_b_val,
    input  logic [SIZE_W-1:0] ld_size,
    output logic              overlap
);
    rec_t  cap_in;
    rec_t  rec_q;
    opnd_t ld_a;
    opnd_t ld_b;
    logic  same_order;
    logic  swapped;
    logic  second_eq;
    logic  both_const;
    logic  range_hit;
    logic  rec_live;

    always_comb begin
        cap_in.a.is_const = st_a_const;
        cap_in.a.val      = st_a_val;
        cap_in.b.is_const = st_b_const;
        cap_in.b.val      = st_b_val;
        cap_in.size       = st_size;
        ld_a.is_const     = ld_a_const;
        ld_a.val          = ld_a_val;
        ld_b.is_const     = ld_b_const;
        ld_b.val          = ld_b_val;
    end

    sld_record u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grp_clear),
        .capture (st_capture),
        .cap_in  (cap_in),
        .rec_q   (rec_q)
    );

    sld_pair_match u_match (
        .st_a       (rec_q.a),
        .st_b       (rec_q.b),
        .ld_a       (ld_a),
        .ld_b       (ld_b),
        .same_order (same_order),
        .swapped    (swapped),
        .second_eq  (second_eq),
        .both_const (both_const)
    );

    sld_range_cmp #(
        .VW (VAL_W),
        .SW (SIZE_W)
    ) u_range (
        .st_off  (rec_q.a.val),
        .st_size (rec_q.size),
        .ld_off  (ld_a.val),
        .ld_size (ld_size),
        .hit     (range_hit)
    );

    always_comb begin
        rec_live = (rec_q.size != '0);
        overlap  = ld_valid && rec_live &&
                   (same_order || swapped || (second_eq && both_const && range_hit));
    end
endmodule

// File: rtl/sld_checker.sv
module sld_checker
    import sld_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              grp_clear,
    input logic              st_capture,
    input rec_t              cap_in,
    input rec_t              rec,
    input logic              ld_valid,
    input opnd_t             ld_a,
    input opnd_t             ld_b,
    input logic              overlap
);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !overlap);

    assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec.size == '0) |-> !overlap);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clear |=> (rec.size == '0));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_capture && !grp_clear) |=> (rec == $past(cap_in)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_capture && !grp_clear) |=> $stable(rec));

    assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && rec.size != '0 && ld_a == rec.a && ld_b == rec.b) |-> overlap);

    assert_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && rec.size != '0 && ld_a == rec.b && ld_b == rec.a) |-> overlap);
endmodule

bind st_ld_overlap sld_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_clear  (grp_clear),
    .st_capture (st_capture),
    .cap_in     (cap_in),
    .rec        (rec_q),
    .ld_valid   (ld_valid),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .overlap    (overlap)
);

// File: tb/sim_st_ld_overlap.sv
module sim_st_ld_overlap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_clear = 1'b0;
    logic        st_capture = 1'b0;
    logic        st_a_const = 1'b0;
    logic [15:0] st_a_val = '0;
    logic        st_b_const = 1'b0;
    logic [15:0] st_b_val = '0;
    logic [3:0]  st_size = '0;
    logic        ld_valid = 1'b0;
    logic        ld_a_const = 1'b0;
    logic [15:0] ld_a_val = '0;
    logic        ld_b_const = 1'b0;
    logic [15:0] ld_b_val = '0;
    logic [3:0]  ld_size = '0;
    logic        overlap;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    st_ld_overlap u0 (
        .clk(clk), .rst_n(rst_n), .grp_clear(grp_clear), .st_capture(st_capture),
        .st_a_const(st_a_const), .st_a_val(st_a_val),
        .st_b_const(st_b_const), .st_b_val(st_b_val), .st_size(st_size),
        .ld_valid(ld_valid), .ld_a_const(ld_a_const), .ld_a_val(ld_a_val),
        .ld_b_const(ld_b_const), .ld_b_val(ld_b_val), .ld_size(ld_size),
        .overlap(overlap)
    );

    task automatic do_store(input logic ac, input logic [15:0] av,
                            input logic bc, input logic [15:0] bv,
                            input logic [3:0] sz, input logic clr);
        @(negedge clk);
        ld_valid   = 1'b0;
        st_capture = 1'b1;
        grp_clear  = clr;
        st_a_const = ac; st_a_val = av;
        st_b_const = bc; st_b_val = bv;
        st_size    = sz;
        @(negedge clk);
        st_capture = 1'b0;
        grp_clear  = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        ld_valid  = 1'b0;
        grp_clear = 1'b1;
        @(negedge clk);
        grp_clear = 1'b0;
    endtask

    task automatic do_load(input logic vld, input logic ac, input logic [15:0] av,
                           input logic bc, input logic [15:0] bv,
                           input logic [3:0] sz, input logic exp, input string tag);
        @(negedge clk);
        ld_valid   = vld;
        ld_a_const = ac; ld_a_val = av;
        ld_b_const = bc; ld_b_val = bv;
        ld_size    = sz;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (overlap !== e) begin
                    n_fail++;
                    $display("FAIL %s: overlap=%b expected=%b", t, overlap, e);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: timeout actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: empty after reset
        do_load(1, 1, 16'd0, 0, 16'd0, 4'd4, 0, "R6 reset empty");

        // store word: const 8 + reg 3
        do_store(1, 16'd8, 0, 16'd3, 4'd4, 0);
        do_load(1, 1, 16'd8, 0, 16'd3, 4'd4, 1, "R1 exact order");
        do_load(1, 0, 16'd3, 1, 16'd8, 4'd4, 1, "R2 swapped order");
        do_load(0, 1, 16'd8, 0, 16'd3, 4'd4, 0, "R10 idle load");
        do_load(1, 0, 16'd8, 0, 16'd3, 4'd4, 0, "R1 flag differs");
        do_load(1, 1, 16'd12, 0, 16'd3, 4'd4, 0, "R3 touching above");
        do_load(1, 1, 16'd10, 0, 16'd3, 4'd4, 1, "R3 intersect above");
        do_load(1, 1, 16'd4, 0, 16'd3, 4'd4, 0, "R4 touching below");
        do_load(1, 1, 16'd6, 0, 16'd3, 4'd4, 1, "R4 intersect below");
        do_load(1, 1, 16'd4, 0, 16'd3, 4'd8, 1, "R5 double load");
        do_load(1, 1, 16'd8, 0, 16'd4, 4'd4, 0, "R3 base differs");

        // replace with double store: const 0 + reg 1
        do_store(1, 16'd0, 0, 16'd1, 4'd8, 0);
        do_load(1, 1, 16'd4, 0, 16'd1, 4'd4, 1, "R5 double store");
        do_load(1, 1, 16'd8, 0, 16'd3, 4'd4, 0, "R7 old store ignored");
        do_load(1, 1, 16'hFFFC, 0, 16'd1, 4'd4, 0, "R9 negative touching");
        do_load(1, 1, 16'hFFFE, 0, 16'd1, 4'd4, 1, "R9 negative intersect");

        // near the positive limit
        do_store(1, 16'h7FFC, 0, 16'd2, 4'd8, 0);
        do_load(1, 1, 16'h7FFE, 0, 16'd2, 4'd4, 1, "R9 no wrap at top");
        do_load(1, 1, 16'h8000, 0, 16'd2, 4'd4, 0, "R9 most negative");

        do_clear();
        do_load(1, 1, 16'h7FFC, 0, 16'd2, 4'd4, 0, "R6 cleared");

        do_store(1, 16'd0, 0, 16'd7, 4'd4, 1);
        do_load(1, 1, 16'd0, 0, 16'd7, 4'd4, 0, "R8 clear wins");

        do_store(1, 16'd0, 0, 16'd7, 4'd4, 0);
        do_load(1, 1, 16'd0, 0, 16'd7, 4'd4, 1, "R7 new capture");

        @(negedge clk);
        ld_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule